// File: doc/BRIEF.md
# Capture/Compare Timer with Compare Shortcuts

A four-channel timer/counter block for a peripheral bus. In timer mode it advances once per prescaled tick of the block clock. In counter mode it advances only on a count strobe. The counter wraps at a selectable width of 8, 16, 24 or 32 bits. Each channel holds one capture/compare value. A capture strobe loads that value from the counter. A bus write loads it directly.

When an increment brings the counter to a channel's value, that channel raises a sticky compare flag. Per-channel shortcut bits let such a compare stop or clear the counter in hardware, with no software involved. A per-channel one-shot option limits the flag to a single firing until the channel's value is rewritten.

Tasks arrive either as single-cycle input pins or as bus writes with bit 0 set. The compare flags are also brought out as output pins. One interrupt line combines the flags that are enabled.

Top module: `cc_timer`

Register map (word address on `busAddr`):

| Address | Name | Meaning |
|---|---|---|
| 0, 1, 2, 3 | start, stop, count, clear tasks | a write with bit 0 set fires the task |
| 4 + n | capture task, channel n | a write with bit 0 set fires the task |
| 8 + n | compare flag, channel n | reads back the flag in bit 0 |
| 12 | shortcuts | bit n = compare n clears; bit 4+n = compare n stops |
| 13 | interrupt enable set | a 1 sets the enable; reads return the enables |
| 14 | interrupt enable clear | a 1 clears the enable; reads return the enables |
| 15 | mode | bit 0: 0 = timer, 1 = counter |
| 16 | width | 0 = 8, 1 = 16, 2 = 24, 3 = 32 bits |
| 17 | prescaler | 0 to 9 |
| 18 + n | capture/compare value, channel n | read/write |
| 22 | one-shot enables | bit n = channel n |

## Requirements
- R1: The counter wraps to 0 at the width chosen in register 16 (code 0 = 8 bits, 1 = 16, 2 = 24, 3 = 32). A compare value above the width's maximum never matches.
- R2: In timer mode (register 15 bit 0 = 0), the counter advances once every 2^P clock cycles, where P is the prescaler in register 17. A write of a value above 9 to register 17 leaves the prescaler unchanged.
- R3: In counter mode (register 15 bit 0 = 1), the counter advances by one per count task while running, and holds otherwise.
- R4: A start task sets the running state and a stop task clears it; stop wins when both arrive together. A stopped counter holds its value.
- R5: A capture task for channel n copies the current counter value into the value register of channel n (address 18 + n).
- R6: Compare flag n is set by the increment that makes the counter equal the value of channel n. It stays set until a write with bit 0 = 0 to address 8 + n. A write with bit 0 = 1 there has no effect.
- R7: Shortcut bit n of register 12 makes compare n clear the counter in the following cycle. A clear task or shortcut clear takes priority over an increment in the same cycle.
- R8: Shortcut bit 4 + n of register 12 makes compare n stop the counter in the following cycle, so the counter holds at the compare value.
- R9: A 1 written to bit n of register 13 sets interrupt enable n; a 1 written to bit n of register 14 clears it; both registers read back the enables. `irq` is the OR over n of (flag n AND enable n).
- R10: With one-shot bit n (register 22) set, compare n fires only once. A bus write to the value register of channel n re-arms it.
- R11: Tasks written over the bus (bit 0 = 1 at addresses 0 to 7) act exactly as the matching task pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock and timer base clock |
| rst_n | input | 1 | active-low asynchronous reset |
| busSel | input | 1 | bus access select |
| busWe | input | 1 | write when high, read when low |
| busAddr | input | 5 | word address |
| busWdata | input | 32 | write data |
| busRdata | output | 32 | read data, combinational from address |
| taskStart | input | 1 | start strobe |
| taskStop | input | 1 | stop strobe |
| taskCount | input | 1 | count strobe (counter mode) |
| taskClear | input | 1 | clear strobe |
| taskCapture | input | 4 | capture strobe per channel |
| evtCompare | output | 4 | sticky compare flag per channel |
| irq | output | 1 | combined interrupt |

## Verification
On every cycle the assertions check several behaviours. Flags stay set unless cleared by a bus write. The interrupt never rises without a set flag. A stop strobe leaves the block stopped. A stopped counter holds still. A clear always lands on zero. The bench scenarios are needed for the rest: wrap at each width, the prescaled tick rate, the one-cycle lag of the shortcuts, one-shot re-arming and the clamped prescaler write. These involve counting over many cycles or following register sequences, which only the stimulus tables and directed tests exercise.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int NUM_CH  = 4;
  localparam int CNT_W   = 32;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 5;
  localparam int PRE_MAX = 9;
  localparam int PRE_W   = $clog2(PRE_MAX + 1);
  localparam int WSEL_W  = 2;
  localparam int BYTE_W  = 8;

  localparam int A_START   = 0;
  localparam int A_STOP    = 1;
  localparam int A_COUNT   = 2;
  localparam int A_CLEAR   = 3;
  localparam int A_CAPT    = 4;
  localparam int A_EVT     = A_CAPT + NUM_CH;
  localparam int A_SHORTS  = A_EVT + NUM_CH;
  localparam int A_INTSET  = A_SHORTS + 1;
  localparam int A_INTCLR  = A_INTSET + 1;
  localparam int A_MODE    = A_INTCLR + 1;
  localparam int A_WIDTH   = A_MODE + 1;
  localparam int A_PRESC   = A_WIDTH + 1;
  localparam int A_CC      = A_PRESC + 1;
  localparam int A_ONESHOT = A_CC + NUM_CH;

  typedef struct packed {
    logic                 run;
    logic                 countPulse;
    logic                 clearNow;
    logic [NUM_CH-1:0]    capture;
    logic [NUM_CH-1:0]    ccWe;
    logic [CNT_W-1:0]     ccData;
    logic                 counterMode;
    logic [WSEL_W-1:0]    widthSel;
    logic [PRE_W-1:0]     preSel;
  } tmrStrobe_t;
endpackage

// File: rtl/cc_timer_dp.sv
module cc_timer_dp
  import cc_timer_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  tmrStrobe_t              strb,
  output logic [NUM_CH-1:0]       hit,
  output logic [NUM_CH*CNT_W-1:0] ccFlat,
  output logic [CNT_W-1:0]        cntVal
);
  logic [PRE_MAX-1:0] preCnt;
  logic [PRE_MAX-1:0] preMask;
  logic [CNT_W-1:0]   widthMask;
  logic [CNT_W-1:0]   nextCnt;
  logic               tick;
  logic               adv;

  // tick every 2^P cycles while running
  assign preMask = ~({PRE_MAX{1'b1}} << strb.preSel);
  assign tick    = (preCnt & preMask) == preMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        preCnt <= '0;
    else if (!strb.run) preCnt <= '0;
    else               preCnt <= preCnt + 1'b1;
  end

  assign widthMask = ~({CNT_W{1'b1}} << (BYTE_W * (int'(strb.widthSel) + 1)));
  assign adv       = strb.run & (strb.counterMode ? strb.countPulse : tick);
  assign nextCnt   = (cntVal + 1'b1) & widthMask;

  // clear beats increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cntVal <= '0;
    else if (strb.clearNow) cntVal <= '0;
    else if (adv)           cntVal <= nextCnt;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [CNT_W-1:0] ccReg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               ccReg <= '0;
      else if (strb.capture[n]) ccReg <= cntVal;
      else if (strb.ccWe[n])    ccReg <= strb.ccData;
    end
    assign ccFlat[n*CNT_W +: CNT_W] = ccReg;
    assign hit[n] = adv & ~strb.clearNow & (nextCnt == ccReg);
  end
endmodule

// File: rtl/cc_timer_ctrl.sv
module cc_timer_ctrl
  import cc_timer_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busSel,
  input  logic                    busWe,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [BUS_W-1:0]        busWdata,
  output logic [BUS_W-1:0]        busRdata,
  input  logic                    taskStart,
  input  logic                    taskStop,
  input  logic                    taskCount,
  input  logic                    taskClear,
  input  logic [NUM_CH-1:0]       taskCapture,
  input  logic [NUM_CH-1:0]       hit,
  input  logic [NUM_CH*CNT_W-1:0] ccFlat,
  output tmrStrobe_t              strb,
  output logic [NUM_CH-1:0]       evt,
  output logic                    irq,
  output logic                    running
);
  logic               wrAcc;
  logic               startReq, stopReq, clearReq, countReq;
  logic               pendStop, pendClear;
  logic [NUM_CH-1:0]  capReq, ccWe, evtClr, fire, armed;
  logic [NUM_CH-1:0]  shortClear, shortStop, intEn, oneShot;
  logic               counterMode;
  logic [WSEL_W-1:0]  widthSel;
  logic [PRE_W-1:0]   preSel;

  function automatic logic isTask(input logic [ADDR_W-1:0] a, input int idx,
                                  input logic acc, input logic b0);
    return acc && (a == ADDR_W'(idx)) && b0;
  endfunction

  assign wrAcc    = busSel & busWe;
  assign startReq = taskStart | isTask(busAddr, A_START, wrAcc, busWdata[0]);
  assign stopReq  = taskStop  | isTask(busAddr, A_STOP,  wrAcc, busWdata[0]) | pendStop;
  assign countReq = taskCount | isTask(busAddr, A_COUNT, wrAcc, busWdata[0]);
  assign clearReq = taskClear | isTask(busAddr, A_CLEAR, wrAcc, busWdata[0]) | pendClear;

  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      capReq[n] = taskCapture[n] | isTask(busAddr, A_CAPT + n, wrAcc, busWdata[0]);
      ccWe[n]   = wrAcc && (busAddr == ADDR_W'(A_CC + n));
      evtClr[n] = wrAcc && (busAddr == ADDR_W'(A_EVT + n)) && !busWdata[0];
    end
  end

  assign fire = hit & (armed | ~oneShot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      pendStop  <= 1'b0;
      pendClear <= 1'b0;
      evt       <= '0;
      armed     <= '1;
    end else begin
      if (stopReq)       running <= 1'b0;
      else if (startReq) running <= 1'b1;
      pendStop  <= |(fire & shortStop);
      pendClear <= |(fire & shortClear);
      evt       <= (evt & ~evtClr) | fire;
      for (int n = 0; n < NUM_CH; n++) begin
        if (ccWe[n])                     armed[n] <= 1'b1;
        else if (fire[n] && oneShot[n])  armed[n] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shortClear  <= '0;
      shortStop   <= '0;
      intEn       <= '0;
      oneShot     <= '0;
      counterMode <= 1'b0;
      widthSel    <= '0;
      preSel      <= '0;
    end else if (wrAcc) begin
      if (busAddr == ADDR_W'(A_SHORTS)) begin
        shortClear <= busWdata[NUM_CH-1:0];
        shortStop  <= busWdata[2*NUM_CH-1:NUM_CH];
      end
      if (busAddr == ADDR_W'(A_INTSET))  intEn <= intEn | busWdata[NUM_CH-1:0];
      if (busAddr == ADDR_W'(A_INTCLR))  intEn <= intEn & ~busWdata[NUM_CH-1:0];
      if (busAddr == ADDR_W'(A_MODE))    counterMode <= busWdata[0];
      if (busAddr == ADDR_W'(A_WIDTH))   widthSel <= busWdata[WSEL_W-1:0];
      if (busAddr == ADDR_W'(A_PRESC) && busWdata <= BUS_W'(PRE_MAX))
        preSel <= busWdata[PRE_W-1:0];
      if (busAddr == ADDR_W'(A_ONESHOT)) oneShot <= busWdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWe) begin
      if (busAddr == ADDR_W'(A_SHORTS))  busRdata = BUS_W'({shortStop, shortClear});
      if (busAddr == ADDR_W'(A_INTSET) || busAddr == ADDR_W'(A_INTCLR))
        busRdata = BUS_W'(intEn);
      if (busAddr == ADDR_W'(A_MODE))    busRdata = BUS_W'(counterMode);
      if (busAddr == ADDR_W'(A_WIDTH))   busRdata = BUS_W'(widthSel);
      if (busAddr == ADDR_W'(A_PRESC))   busRdata = BUS_W'(preSel);
      if (busAddr == ADDR_W'(A_ONESHOT)) busRdata = BUS_W'(oneShot);
      for (int n = 0; n < NUM_CH; n++) begin
        if (busAddr == ADDR_W'(A_EVT + n)) busRdata = BUS_W'(evt[n]);
        if (busAddr == ADDR_W'(A_CC + n))  busRdata = BUS_W'(ccFlat[n*CNT_W +: CNT_W]);
      end
    end
  end

  assign irq = |(evt & intEn);

  always_comb begin
    strb.run         = running & ~stopReq;
    strb.countPulse  = countReq;
    strb.clearNow    = clearReq;
    strb.capture     = capReq;
    strb.ccWe        = ccWe;
    strb.ccData      = busWdata[CNT_W-1:0];
    strb.counterMode = counterMode;
    strb.widthSel    = widthSel;
    strb.preSel      = preSel;
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              taskStart,
  input  logic              taskStop,
  input  logic              taskCount,
  input  logic              taskClear,
  input  logic [NUM_CH-1:0] taskCapture,
  output logic [NUM_CH-1:0] evtCompare,
  output logic              irq
);
  tmrStrobe_t              strb;
  logic [NUM_CH-1:0]       hit;
  logic [NUM_CH*CNT_W-1:0] ccFlat;
  logic [CNT_W-1:0]        cntVal;
  logic                    running;

  cc_timer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .taskStart(taskStart), .taskStop(taskStop), .taskCount(taskCount),
    .taskClear(taskClear), .taskCapture(taskCapture),
    .hit(hit), .ccFlat(ccFlat), .strb(strb),
    .evt(evtCompare), .irq(irq), .running(running)
  );

  cc_timer_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .hit(hit), .ccFlat(ccFlat), .cntVal(cntVal)
  );
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
  import cc_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BUS_W-1:0]  busWdata,
  input logic              taskStop,
  input logic [NUM_CH-1:0] evtCompare,
  input logic              irq,
  input logic [CNT_W-1:0]  cntVal,
  input logic              running,
  input tmrStrobe_t        strb
);
  logic [NUM_CH-1:0] clrMask;
  always_comb begin
    for (int n = 0; n < NUM_CH; n++)
      clrMask[n] = busSel && busWe && (busAddr == ADDR_W'(A_EVT + n)) && !busWdata[0];
  end

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evtCompare) & ~$past(clrMask)) & ~evtCompare) == '0));

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|evtCompare));

  // R4
  stop_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taskStop |=> !running);

  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !strb.clearNow) |=> $stable(cntVal));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearNow |=> (cntVal == '0));
endmodule

bind cc_timer cc_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .taskStop(taskStop),
  .evtCompare(evtCompare), .irq(irq), .cntVal(cntVal),
  .running(running), .strb(strb)
);

// File: tb/cc_timer_tb.sv
module cc_timer_tb;
  import cc_timer_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              busSel = 1'b0, busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [BUS_W-1:0]  busWdata = '0;
  logic [BUS_W-1:0]  busRdata;
  logic              taskStart = 1'b0, taskStop = 1'b0, taskCount = 1'b0, taskClear = 1'b0;
  logic [NUM_CH-1:0] taskCapture = '0;
  logic [NUM_CH-1:0] evtCompare;
  logic              irq;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  cc_timer u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = ADDR_W'(a); busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    busSel = 1'b1; busWe = 1'b0; busAddr = ADDR_W'(a);
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic pulseStart(); taskStart = 1'b1; @(negedge clk); taskStart = 1'b0; endtask
  task automatic pulseStop();  taskStop  = 1'b1; @(negedge clk); taskStop  = 1'b0; endtask
  task automatic pulseCount(input int k);
    for (int i = 0; i < k; i++) begin
      taskCount = 1'b1; @(negedge clk); taskCount = 1'b0;
    end
  endtask
  task automatic pulseCap(input int ch);
    taskCapture[ch] = 1'b1; @(negedge clk); taskCapture[ch] = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  w;
    logic [31:0] n;
    logic [31:0] cc;
    logic [31:0] expCap;
    logic        expEvt;
  } vec_t;

  // counter-mode width/wrap vectors (R1, R3)
  localparam vec_t VECS [5] = '{
    '{2'd0, 32'd300,  32'd44,   32'd44,   1'b1},
    '{2'd0, 32'd256,  32'd300,  32'd0,    1'b0},
    '{2'd1, 32'd1000, 32'd1000, 32'd1000, 1'b1},
    '{2'd2, 32'd20,   32'd21,   32'd20,   1'b0},
    '{2'd3, 32'd7,    32'd7,    32'd7,    1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R6 reset flags", 32'(evtCompare), 0);
    check("R9 reset irq", 32'(irq), 0);
    rd(A_INTSET, d);  check("R9 reset enables", d, 0);
    rd(A_PRESC, d);   check("R2 reset prescaler", d, 0);

    wr(A_MODE, 1);
    foreach (VECS[i]) begin
      wr(A_CLEAR, 1);
      wr(A_WIDTH, 32'(VECS[i].w));
      wr(A_CC + 0, VECS[i].cc);
      wr(A_EVT + 0, 0);
      wr(A_START, 1);
      pulseCount(int'(VECS[i].n));
      pulseCap(1);
      rd(A_CC + 1, d);       check("R1 R5 wrap capture", d, VECS[i].expCap);
      rd(A_EVT + 0, d);      check("R1 R6 compare flag", d, 32'(VECS[i].expEvt));
    end

    // R3: no count strobes, no movement
    repeat (10) @(negedge clk);
    pulseCap(1);
    rd(A_CC + 1, d); check("R3 idle hold", d, 7);
    // R4: count while stopped ignored; R11 bus stop
    wr(A_STOP, 1);
    pulseCount(3);
    wr(A_CAPT + 1, 1);
    rd(A_CC + 1, d); check("R4 R11 stopped hold", d, 7);

    // R7: clear and count in the same cycle
    pulseStart();
    taskClear = 1'b1; taskCount = 1'b1; @(negedge clk);
    taskClear = 1'b0; taskCount = 1'b0;
    pulseCap(1);
    rd(A_CC + 1, d); check("R7 clear priority", d, 0);

    // R7: shortcut clear on compare 0 at 3
    wr(A_CC + 0, 3);
    wr(A_SHORTS, 32'h1);
    wr(A_EVT + 0, 0);
    pulseCount(5);
    pulseCap(1);
    rd(A_CC + 1, d);  check("R7 shortcut clear", d, 1);
    rd(A_EVT + 0, d); check("R7 flag at clear", d, 1);
    wr(A_SHORTS, 0);

    // R2: timer mode prescaler 2, 40 edges
    pulseStop();
    wr(A_CLEAR, 1);
    wr(A_MODE, 0);
    wr(A_PRESC, 2);
    pulseStart();
    repeat (39) @(negedge clk);
    pulseStop();
    wr(A_CAPT + 3, 1);
    rd(A_CC + 3, d); check("R2 prescale 4", d, 9);
    repeat (20) @(negedge clk);
    pulseCap(3);
    rd(A_CC + 3, d); check("R4 timer stopped hold", d, 9);
    wr(A_PRESC, 12);
    rd(A_PRESC, d);  check("R2 prescale write above 9 ignored", d, 2);

    // R2: prescaler 0, 13 edges
    wr(A_CLEAR, 1);
    wr(A_PRESC, 0);
    pulseStart();
    repeat (12) @(negedge clk);
    pulseStop();
    pulseCap(3);
    rd(A_CC + 3, d); check("R2 prescale 1", d, 12);

    // R8: shortcut stop on compare 1 at 6
    wr(A_CLEAR, 1);
    wr(A_CC + 1, 6);
    wr(A_SHORTS, 32'h20);
    wr(A_EVT + 1, 0);
    pulseStart();
    repeat (30) @(negedge clk);
    pulseCap(2);
    rd(A_CC + 2, d);  check("R8 shortcut stop", d, 6);
    rd(A_EVT + 1, d); check("R8 flag", d, 1);
    wr(A_SHORTS, 0);

    // R6: write 1 ignored, write 0 clears
    wr(A_EVT + 0, 1);
    rd(A_EVT + 0, d); check("R6 write one ignored", d, 1);
    wr(A_EVT + 0, 0);
    rd(A_EVT + 0, d); check("R6 write zero clears", d, 0);

    // R9: enables
    wr(A_INTSET, 32'h1);
    check("R9 enabled but flag clear", 32'(irq), 0);
    wr(A_INTSET, 32'h2);
    check("R9 irq on", 32'(irq), 1);
    rd(A_INTCLR, d);  check("R9 enable readback", d, 3);
    wr(A_INTCLR, 32'h2);
    check("R9 irq off", 32'(irq), 0);
    rd(A_INTSET, d);  check("R9 enable after clear", d, 1);

    // R10: one-shot on channel 2
    wr(A_MODE, 1);
    wr(A_CLEAR, 1);
    wr(A_CC + 2, 2);
    wr(A_ONESHOT, 32'h4);
    wr(A_EVT + 2, 0);
    wr(A_START, 1);
    pulseCount(3);
    rd(A_EVT + 2, d); check("R10 R11 first fire", d, 1);
    wr(A_EVT + 2, 0);
    wr(A_CLEAR, 1);
    pulseCount(3);
    rd(A_EVT + 2, d); check("R10 no second fire", d, 0);
    wr(A_CC + 2, 2);
    wr(A_CLEAR, 1);
    pulseCount(3);
    rd(A_EVT + 2, d); check("R10 rearm", d, 1);
    check("R6 flag pin", 32'(evtCompare[2]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule